// File: doc/BRIEF.md
# Radio Auto Transaction Sequencer

This block drives a packet radio through a whole acknowledged exchange with no host steps in the middle. For a send, the host loads a packet, gives its length and pulses the go bit. The sequencer then turns on the crystal oscillator and waits for it to report ready. Next it turns on the frequency synthesizer and waits for lock. It asks the modem to send the data packet, turns the radio around to receive, and waits for the acknowledge. It stops when the acknowledge arrives or when a programmable number of cycles has passed, whichever is first. It then falls back to a rest state. That rest state keeps the oscillator running (idle) or turns everything off (sleep), as the host chooses.

For a receive, the host holds the receive-transaction enable. The sequencer powers up the same way and listens. Each valid data packet is written to the receive buffer and raises an interrupt. The sequencer then sends an acknowledge through a separate request line and goes back to listening. Acknowledge traffic in either direction never strobes the receive buffer write or the data-send request, so neither packet buffer is touched by it. The modem, the RF front end and the buffers sit outside the block and are seen only as request and ready lines.

Top module: `radio_txn_seq`

## Requirements
- R1: After reset the block is at rest, with tx_busy, rx_active, irq, last_ack_ok, last_tmo, tx_req, ack_tx_req, synth_en and rx_en all 0.
- R2: A tx_go pulse at rest raises osc_en and holds synth_en low until osc_ready is seen. synth_en then rises with osc_en still high, and the block waits for synth_locked.
- R3: After synth_locked in a send, tx_req is high until tx_done, and tx_len_out shows the length captured with the accepted tx_go.
- R4: After tx_done, tx_req falls and rx_en rises. An rx_ack_seen while waiting ends the send with last_ack_ok=1 and last_tmo=0.
- R5: If no acknowledge comes in ack_limit consecutive waiting cycles, the send ends after the last of them with last_tmo=1 and last_ack_ok=0. An acknowledge in that last cycle still counts as received. An ack_limit of 0 acts as 1.
- R6: At rest, synth_en, rx_en, tx_req and ack_tx_req are 0, and osc_en equals end_idle (1 = idle, 0 = sleep).
- R7: tx_busy is 1 from an accepted tx_go until the send ends. A tx_go while busy, or during a receive transaction, is ignored: no restart and no change to tx_len_out.
- R8: With rx_txn_en high at rest, the block powers up as in R2 and then listens (rx_en=1). A valid packet moves it to ack_tx_req=1 until tx_done, and then it listens again. Dropping rx_txn_en while listening returns the block to rest.
- R9: rx_buf_we is high only in a listening cycle with rx_pkt_valid. It stays 0 while an acknowledge is awaited or sent. Sending an acknowledge never raises tx_req.
- R10: irq goes to 1 on each received data packet and at the end of each send, and stays set until irq_clear. A set in the same cycle as a clear wins.
- R11: If tx_go and rx_txn_en are both high at rest, the send starts and the receive transaction does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_go | input | 1 | Go pulse that starts a send |
| tx_len | input | LEN_W | Payload length, captured with an accepted go |
| end_idle | input | 1 | Rest state select: 1 idle, 0 sleep |
| rx_txn_en | input | 1 | Receive transaction enable |
| ack_limit | input | TMO_W | Acknowledge wait limit in cycles |
| irq_clear | input | 1 | Clears the interrupt |
| osc_ready | input | 1 | Oscillator ready |
| synth_locked | input | 1 | Synthesizer locked |
| tx_done | input | 1 | Modem finished sending a packet |
| rx_pkt_valid | input | 1 | Modem received a valid packet |
| rx_ack_seen | input | 1 | Modem detected an acknowledge |
| osc_en | output | 1 | Oscillator enable |
| synth_en | output | 1 | Synthesizer enable |
| tx_req | output | 1 | Send the data packet from the transmit buffer |
| tx_len_out | output | LEN_W | Captured length for the data send |
| ack_tx_req | output | 1 | Send an acknowledge |
| rx_en | output | 1 | Receiver enable |
| rx_buf_we | output | 1 | Receive buffer write strobe |
| tx_busy | output | 1 | Go bit read-back, high while a send runs |
| rx_active | output | 1 | Receive transaction running |
| irq | output | 1 | Sticky interrupt request |
| last_ack_ok | output | 1 | Last send ended with an acknowledge |
| last_tmo | output | 1 | Last send ended by timeout |

## Verification
The send path is swept over every wait limit from 0 to 4, with the acknowledge placed in each waiting cycle or left out, under varied oscillator and lock delays and both rest choices. This separates an off-by-one timeout from a correct one, and shows whether a last-cycle acknowledge beats the timeout. A valid-packet flag is held high throughout the acknowledge wait, and a go pulse is injected mid-transaction, to show that neither the buffers nor the captured length are disturbed. The receive path runs several packets with different gaps and acknowledge durations while counting buffer strobes. A final run raises both start requests together to check which one wins.

// File: rtl/rts_pkg.sv
package rts_pkg;

  typedef enum logic [2:0] {
    ST_REST = 3'd0,
    ST_OSC  = 3'd1,
    ST_SYN  = 3'd2,
    ST_TXD  = 3'd3,
    ST_ACKW = 3'd4,
    ST_RXL  = 3'd5,
    ST_RXA  = 3'd6
  } rts_state_e;

  // The wait window is over once the cycle being spent is the last allowed one.
  // A limit of zero behaves like one.
  function automatic logic rts_window_over(input int unsigned elapsed,
                                           input int unsigned limit);
    return (elapsed + 1) >= limit;
  endfunction

endpackage

// File: rtl/rts_ack_timer.sv
module rts_ack_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  import rts_pkg::*;

  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = run && rts_window_over(32'(cnt_q), 32'(limit));

endmodule

// File: rtl/rts_fsm.sv
module rts_fsm #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_go,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             end_idle,
  input  logic             rx_txn_en,
  input  logic             osc_ready,
  input  logic             synth_locked,
  input  logic             tx_done,
  input  logic             rx_pkt_valid,
  input  logic             rx_ack_seen,
  input  logic             tmo_expired,
  output logic             osc_en,
  output logic             synth_en,
  output logic             tx_req,
  output logic [LEN_W-1:0] tx_len_out,
  output logic             ack_tx_req,
  output logic             rx_en,
  output logic             rx_buf_we,
  output logic             tx_busy,
  output logic             rx_active,
  output logic             ack_wait,
  output logic             ack_hit,
  output logic             tmo_end
);
  import rts_pkg::*;

  rts_state_e       st_q, st_d;
  logic             mode_rx_q;
  logic [LEN_W-1:0] len_q;
  logic             at_rest;

  assign at_rest = (st_q == ST_REST);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_REST: if (tx_go || rx_txn_en) st_d = ST_OSC;
      ST_OSC:  if (osc_ready)          st_d = ST_SYN;
      ST_SYN:  if (synth_locked)       st_d = mode_rx_q ? ST_RXL : ST_TXD;
      ST_TXD:  if (tx_done)            st_d = ST_ACKW;
      ST_ACKW: if (rx_ack_seen || tmo_expired) st_d = ST_REST;
      ST_RXL: begin
        if (rx_pkt_valid)    st_d = ST_RXA;
        else if (!rx_txn_en) st_d = ST_REST;
      end
      ST_RXA:  if (tx_done)            st_d = ST_RXL;
      default: st_d = ST_REST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_REST;
      mode_rx_q <= 1'b0;
      len_q     <= '0;
    end else begin
      st_q <= st_d;
      if (at_rest && tx_go) begin
        mode_rx_q <= 1'b0;
        len_q     <= tx_len;
      end else if (at_rest && rx_txn_en) begin
        mode_rx_q <= 1'b1;
      end
    end
  end

  always_comb begin
    osc_en     = at_rest ? end_idle : 1'b1;
    synth_en   = (st_q != ST_REST) && (st_q != ST_OSC);
    tx_req     = (st_q == ST_TXD);
    ack_tx_req = (st_q == ST_RXA);
    ack_wait   = (st_q == ST_ACKW);
    rx_en      = ack_wait || (st_q == ST_RXL);
    rx_buf_we  = (st_q == ST_RXL) && rx_pkt_valid;
    tx_busy    = !at_rest && !mode_rx_q;
    rx_active  = !at_rest && mode_rx_q;
    ack_hit    = ack_wait && rx_ack_seen;
    tmo_end    = ack_wait && !rx_ack_seen && tmo_expired;
  end

  assign tx_len_out = len_q;

endmodule

// File: rtl/rts_status.sv
module rts_status (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pkt_evt,
  input  logic ack_hit,
  input  logic tmo_end,
  input  logic irq_clear,
  output logic irq,
  output logic last_ack_ok,
  output logic last_tmo
);
  logic irq_set;

  assign irq_set = rx_pkt_evt || ack_hit || tmo_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq         <= 1'b0;
      last_ack_ok <= 1'b0;
      last_tmo    <= 1'b0;
    end else begin
      if (irq_set)        irq <= 1'b1;
      else if (irq_clear) irq <= 1'b0;
      if (ack_hit) begin
        last_ack_ok <= 1'b1;
        last_tmo    <= 1'b0;
      end else if (tmo_end) begin
        last_ack_ok <= 1'b0;
        last_tmo    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/radio_txn_seq.sv
module radio_txn_seq #(
  parameter int LEN_W = 8,
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_go,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             end_idle,
  input  logic             rx_txn_en,
  input  logic [TMO_W-1:0] ack_limit,
  input  logic             irq_clear,
  input  logic             osc_ready,
  input  logic             synth_locked,
  input  logic             tx_done,
  input  logic             rx_pkt_valid,
  input  logic             rx_ack_seen,
  output logic             osc_en,
  output logic             synth_en,
  output logic             tx_req,
  output logic [LEN_W-1:0] tx_len_out,
  output logic             ack_tx_req,
  output logic             rx_en,
  output logic             rx_buf_we,
  output logic             tx_busy,
  output logic             rx_active,
  output logic             irq,
  output logic             last_ack_ok,
  output logic             last_tmo
);

  logic ack_wait_w;
  logic ack_hit_w;
  logic tmo_end_w;
  logic tmo_expired_w;

  rts_ack_timer #(.TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ack_wait_w),
    .limit   (ack_limit),
    .expired (tmo_expired_w)
  );

  rts_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_go        (tx_go),
    .tx_len       (tx_len),
    .end_idle     (end_idle),
    .rx_txn_en    (rx_txn_en),
    .osc_ready    (osc_ready),
    .synth_locked (synth_locked),
    .tx_done      (tx_done),
    .rx_pkt_valid (rx_pkt_valid),
    .rx_ack_seen  (rx_ack_seen),
    .tmo_expired  (tmo_expired_w),
    .osc_en       (osc_en),
    .synth_en     (synth_en),
    .tx_req       (tx_req),
    .tx_len_out   (tx_len_out),
    .ack_tx_req   (ack_tx_req),
    .rx_en        (rx_en),
    .rx_buf_we    (rx_buf_we),
    .tx_busy      (tx_busy),
    .rx_active    (rx_active),
    .ack_wait     (ack_wait_w),
    .ack_hit      (ack_hit_w),
    .tmo_end      (tmo_end_w)
  );

  rts_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_pkt_evt  (rx_buf_we),
    .ack_hit     (ack_hit_w),
    .tmo_end     (tmo_end_w),
    .irq_clear   (irq_clear),
    .irq         (irq),
    .last_ack_ok (last_ack_ok),
    .last_tmo    (last_tmo)
  );

endmodule

// File: rtl/rts_chk.sv
module rts_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_en,
  input logic             synth_en,
  input logic             tx_req,
  input logic             ack_tx_req,
  input logic             rx_en,
  input logic             rx_buf_we,
  input logic             tx_busy,
  input logic             rx_active,
  input logic             irq,
  input logic             last_ack_ok,
  input logic             last_tmo,
  input logic [LEN_W-1:0] tx_len_out,
  input logic             ack_hit,
  input logic             tmo_end
);

  AST_SYNTH_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    synth_en |-> osc_en); // R2

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy)) |-> $stable(tx_len_out)); // R7

  AST_ACK_ENDS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> (!tx_busy && last_ack_ok && !last_tmo)); // R4

  AST_TMO_ENDS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_end |=> (!tx_busy && last_tmo && !last_ack_ok)); // R5

  AST_BUF_WE_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_buf_we |-> (rx_en && rx_active && !ack_tx_req)); // R9

  AST_ACK_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ack_tx_req |-> !tx_req); // R9

  AST_PKT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_buf_we |=> irq); // R10

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |-> !tx_busy); // R11

endmodule

bind radio_txn_seq rts_chk #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .osc_en      (osc_en),
  .synth_en    (synth_en),
  .tx_req      (tx_req),
  .ack_tx_req  (ack_tx_req),
  .rx_en       (rx_en),
  .rx_buf_we   (rx_buf_we),
  .tx_busy     (tx_busy),
  .rx_active   (rx_active),
  .irq         (irq),
  .last_ack_ok (last_ack_ok),
  .last_tmo    (last_tmo),
  .tx_len_out  (tx_len_out),
  .ack_hit     (ack_hit_w),
  .tmo_end     (tmo_end_w)
);

// File: tb/radio_txn_seq_tb.sv
module radio_txn_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_go = 1'b0;
  logic [7:0] tx_len = '0;
  logic       end_idle = 1'b0;
  logic       rx_txn_en = 1'b0;
  logic [7:0] ack_limit = '0;
  logic       irq_clear = 1'b0;
  logic       osc_ready = 1'b0;
  logic       synth_locked = 1'b0;
  logic       tx_done = 1'b0;
  logic       rx_pkt_valid = 1'b0;
  logic       rx_ack_seen = 1'b0;
  logic       osc_en, synth_en, tx_req, ack_tx_req, rx_en, rx_buf_we;
  logic       tx_busy, rx_active, irq, last_ack_ok, last_tmo;
  logic [7:0] tx_len_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  radio_txn_seq #(.LEN_W(8), .TMO_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .tx_len(tx_len),
    .end_idle(end_idle), .rx_txn_en(rx_txn_en), .ack_limit(ack_limit),
    .irq_clear(irq_clear), .osc_ready(osc_ready), .synth_locked(synth_locked),
    .tx_done(tx_done), .rx_pkt_valid(rx_pkt_valid), .rx_ack_seen(rx_ack_seen),
    .osc_en(osc_en), .synth_en(synth_en), .tx_req(tx_req),
    .tx_len_out(tx_len_out), .ack_tx_req(ack_tx_req), .rx_en(rx_en),
    .rx_buf_we(rx_buf_we), .tx_busy(tx_busy), .rx_active(rx_active),
    .irq(irq), .last_ack_ok(last_ack_ok), .last_tmo(last_tmo)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_rest(input string req);
    chk({req, " synth_en"}, synth_en, 0);
    chk({req, " rx_en"}, rx_en, 0);
    chk({req, " tx_req"}, tx_req, 0);
    chk({req, " ack_tx_req"}, ack_tx_req, 0);
    chk({req, " osc_en"}, osc_en, end_idle);
  endtask

  // One full send; ack_k equal to the effective limit means no acknowledge.
  task automatic run_tx(input int len, input int lim, input int okd,
                        input int skd, input int ack_k, input bit idle);
    int  teff;
    bit  ended;
    bit  got_ack;
    teff = (lim == 0) ? 1 : lim;
    end_idle = idle;
    ack_limit = 8'(lim);
    tx_len = 8'(len);
    tx_go = 1'b1;
    step();
    tx_go = 1'b0;
    chk("R2 osc_en on go", osc_en, 1);
    chk("R2 synth_en before ready", synth_en, 0);
    chk("R7 busy set", tx_busy, 1);
    tx_go = 1'b1;
    tx_len = 8'(len ^ 8'hFF);
    step();
    tx_go = 1'b0;
    tx_len = 8'(len);
    chk("R7 go while busy", tx_busy, 1);
    chk("R2 synth_en still off", synth_en, 0);
    repeat (okd) step();
    osc_ready = 1'b1;
    step();
    osc_ready = 1'b0;
    chk("R2 synth_en after ready", synth_en, 1);
    chk("R2 osc_en kept", osc_en, 1);
    chk("R3 no send before lock", tx_req, 0);
    repeat (skd) step();
    synth_locked = 1'b1;
    step();
    synth_locked = 1'b0;
    chk("R3 tx_req", tx_req, 1);
    chk("R7 length not re-latched", tx_len_out, len);
    tx_done = 1'b1;
    step();
    tx_done = 1'b0;
    chk("R4 rx_en in wait", rx_en, 1);
    chk("R4 tx_req dropped", tx_req, 0);
    ended = 0;
    got_ack = (ack_k < teff);
    for (int c = 0; c < teff && !ended; c++) begin
      rx_pkt_valid = 1'b1;
      rx_ack_seen = (c == ack_k);
      #1;
      chk("R9 no buffer write in ack wait", rx_buf_we, 0);
      step();
      rx_pkt_valid = 1'b0;
      rx_ack_seen = 1'b0;
      if (c == ack_k || c == teff - 1) ended = 1;
      else chk("R5 still waiting", rx_en, 1);
    end
    chk("R7 busy cleared", tx_busy, 0);
    check_rest("R6");
    chk("R4 ack flag", last_ack_ok, got_ack);
    chk("R5 timeout flag", last_tmo, !got_ack);
    chk("R10 irq at send end", irq, 1);
    irq_clear = 1'b1;
    step();
    irq_clear = 1'b0;
    chk("R10 irq cleared", irq, 0);
  endtask

  initial begin
    step();
    step();
    chk("R1 tx_busy", tx_busy, 0);
    chk("R1 rx_active", rx_active, 0);
    chk("R1 irq", irq, 0);
    chk("R1 last_ack_ok", last_ack_ok, 0);
    chk("R1 last_tmo", last_tmo, 0);
    check_rest("R1");
    rst_n = 1'b1;
    step();
    end_idle = 1'b1;
    #1;
    chk("R6 idle keeps oscillator", osc_en, 1);
    end_idle = 1'b0;
    #1;
    chk("R6 sleep stops oscillator", osc_en, 0);

    // Send sweep
    for (int lim = 0; lim <= 4; lim++) begin
      for (int ak = 0; ak <= ((lim == 0) ? 1 : lim); ak++) begin
        for (int v = 0; v < 4; v++) begin
          run_tx(8'h11 + lim * 16 + ak * 3 + v, lim, v % 2, v / 2, ak, bit'(v % 2 == 0));
        end
      end
    end

    // Receive transaction
    begin
      int we_count;
      we_count = 0;
      end_idle = 1'b1;
      rx_txn_en = 1'b1;
      step();
      chk("R8 rx_active", rx_active, 1);
      chk("R8 not a send", tx_busy, 0);
      chk("R8 power-up osc", osc_en, 1);
      chk("R8 synth off before ready", synth_en, 0);
      osc_ready = 1'b1;
      synth_locked = 1'b1;
      step();
      step();
      osc_ready = 1'b0;
      synth_locked = 1'b0;
      chk("R8 listening", rx_en, 1);
      for (int p = 0; p < 4; p++) begin
        repeat (p) begin
          #1;
          if (rx_buf_we) we_count++;
          step();
        end
        rx_pkt_valid = 1'b1;
        #1;
        chk("R9 write on packet", rx_buf_we, 1);
        if (rx_buf_we) we_count++;
        step();
        chk("R8 ack send", ack_tx_req, 1);
        chk("R9 ack is not data", tx_req, 0);
        chk("R8 rx off while acking", rx_en, 0);
        #1;
        chk("R9 no write while acking", rx_buf_we, 0);
        chk("R10 irq on packet", irq, 1);
        rx_pkt_valid = 1'b0;
        tx_go = 1'b1;
        step();
        tx_go = 1'b0;
        chk("R7 go ignored in receive", tx_busy, 0);
        repeat (p) step();
        tx_done = 1'b1;
        step();
        tx_done = 1'b0;
        chk("R8 back to listen", rx_en, 1);
        chk("R8 ack done", ack_tx_req, 0);
        irq_clear = 1'b1;
        step();
        irq_clear = 1'b0;
      end
      chk("R9 one write per packet", we_count, 4);
      rx_txn_en = 1'b0;
      step();
      chk("R8 rx_active off", rx_active, 0);
      check_rest("R8");
    end

    // Both requests together at rest
    ack_limit = 8'd3;
    tx_len = 8'h5A;
    tx_go = 1'b1;
    rx_txn_en = 1'b1;
    step();
    tx_go = 1'b0;
    rx_txn_en = 1'b0;
    chk("R11 send wins", tx_busy, 1);
    chk("R11 receive not started", rx_active, 0);
    osc_ready = 1'b1;
    synth_locked = 1'b1;
    tx_done = 1'b1;
    rx_ack_seen = 1'b1;
    repeat (4) step();
    osc_ready = 1'b0;
    synth_locked = 1'b0;
    tx_done = 1'b0;
    rx_ack_seen = 1'b0;
    chk("R11 send completed", tx_busy, 0);
    chk("R11 ended with ack", last_ack_ok, 1);
    chk("R3 length of priority send", tx_len_out, 8'h5A);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule